// File: doc/BRIEF.md
# CAN Interrupt Cause and Pending Controller

This block gathers interrupt-pending flags for a bank of message objects, numbered from 1, together with a status-change flag and an error flag. It reports them to a host through a small register file. A host interrupt handler reads one cause register. That register names the single most urgent source: a fixed status code when a status change is waiting, otherwise the number of the lowest-numbered message object that is pending. The full set of object flags can be read at once through two 16-bit pending words.

Flags are cleared in two ways. Reading the status register retires the status and error flags. An individual object flag is retired by a command: the host first sets the clear bit in the command-mask register and then writes the object number into the command-request register. That register shows a busy bit while the command runs. Three enable bits gate a single registered interrupt line. Message storage, bus signalling and error counting live elsewhere. Object, status-change and error events arrive as one-cycle input pulses.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset, all pending flags, the control bits, the command-mask bit, the busy bit, the stored object number and `irq` are zero, and every register reads zero.
- R2: A pulse on `obj_evt[k]` sets the flag of object k+1 from the next cycle on. Objects 1..16 read at address 3 (bit k) and objects 17..32 read at address 4 (bit k-16).
- R3: The cause register (address 2) reads 16'h8000 while the status flag is set. Otherwise it reads the lowest set object number, and 0 when no flag is set.
- R4: A read strobe at address 1 clears the status flag and the error flag at the next edge. Address 1 reads the error flag in bit 1 and the status flag in bit 0. An event arriving in the same cycle as the read keeps its flag set.
- R5: A write to the command-request register (address 6) that is accepted, with the command-mask bit (address 5, bit 0) set, clears the flag of the object numbered in write bits 5:0. Object number 0 or a number above 32 clears nothing, and the write clears nothing when the mask bit is 0.
- R6: An accepted command-request write makes the busy bit (address 6, bit 15) read 1 for exactly 3 cycles. Bits 5:0 of address 6 hold the last accepted object number. A command-request write made while busy is ignored.
- R7: When an object event and a clear command for the same object fall in the same cycle, the flag stays set.
- R8: `irq` is registered. It is 1 in a cycle only if, in the previous cycle, control bit 0 (master) was set and at least one of the following held: some object flag was set; control bit 1 and the status flag were set; or control bit 2 and the error flag were set.
- R9: A write to address 0 stores bits 2:0 as the control bits, and address 0 reads them back in bits 2:0. Address 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| obj_evt | input | 32 | One-cycle pending event per message object (bit k is object k+1) |
| stat_evt | input | 1 | Status-change event pulse |
| err_evt | input | 1 | Bus-off entry or error-limit event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects only) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt line to the host |

## Verification
The assertions assume that the event inputs and strobes are driven synchronously and settle before each clock edge. They also assume a host that may issue command writes at any time, including while busy. The stimulus therefore drives every input half a cycle away from the sampling edge. It mixes directed sequences with random traffic in which read and write strobes never coincide, so the status-read side effect is never combined with a write. Object events are sparse and random, so that clears, same-cycle set/clear collisions and busy-time writes all happen many times.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;
   typedef enum logic [2:0] {
      SEL_CTRL  = 3'd0,
      SEL_STAT  = 3'd1,
      SEL_CAUSE = 3'd2,
      SEL_PLO   = 3'd3,
      SEL_PHI   = 3'd4,
      SEL_CMASK = 3'd5,
      SEL_CREQ  = 3'd6,
      SEL_NONE  = 3'd7
   } reg_sel_e;

   localparam int CTRL_MASTER = 0;
   localparam int CTRL_STAT   = 1;
   localparam int CTRL_ERR    = 2;
endpackage

// File: rtl/can_irq_pend.sv
module can_irq_pend #(
   parameter int N = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic flag_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= set_i[i] | (flag_q & ~clr_i[i]);
      end
      assign pend_o[i] = flag_q;

      // a new event always wins over a clear in the same cycle
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> pend_o[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_o[i] && !clr_i[i]) |=> pend_o[i]);
   end
endmodule

// File: rtl/can_irq_prio.sv
module can_irq_prio #(
   parameter int              N           = 32,
   parameter int              CW          = 16,
   parameter logic [CW-1:0]   STATUS_CODE = 16'h8000
) (
   input  logic [N-1:0]  pend_i,
   input  logic          stat_i,
   output logic [CW-1:0] cause_o
);
   logic [CW-1:0] lowest;

   always_comb begin
      lowest = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend_i[i]) lowest = CW'(i + 1);
      end
   end

   assign cause_o = stat_i ? STATUS_CODE : lowest;
endmodule

// File: rtl/can_irq_cmd.sv
module can_irq_cmd #(
   parameter int N        = 32,
   parameter int BUSY_CYC = 3,
   parameter int NUM_W    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_wr,
   input  logic [NUM_W-1:0] req_num,
   input  logic             mask_clr,
   output logic             busy_o,
   output logic [NUM_W-1:0] num_o,
   output logic [N-1:0]     clr_o
);
   localparam int CNT_W = $clog2(BUSY_CYC + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [NUM_W-1:0] num_q;
   logic             accept;

   assign busy_o = (cnt_q != '0);
   assign accept = req_wr & ~busy_o;
   assign num_o  = num_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         num_q <= '0;
      end else if (accept) begin
         cnt_q <= CNT_W'(BUSY_CYC);
         num_q <= req_num;
      end else if (busy_o) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   for (genvar i = 0; i < N; i++) begin : g_dec
      assign clr_o[i] = accept & mask_clr & (req_num == NUM_W'(i + 1));
   end

   assert_busy_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> busy_o);
   assert_ignore_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && req_wr) |=> $stable(num_o));
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BUSY_CYC));
   assert_clr_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));
endmodule

// File: rtl/can_irq_ctrl.sv
module can_irq_ctrl
   import can_irq_pkg::*;
#(
   parameter int            NUM_OBJ     = 32,
   parameter int            REG_W       = 16,
   parameter int            BUSY_CYC    = 3,
   parameter logic [15:0]   STATUS_CODE = 16'h8000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_OBJ-1:0] obj_evt,
   input  logic               stat_evt,
   input  logic               err_evt,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [2:0]         reg_addr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   output logic               irq
);
   localparam int NUM_W = $clog2(NUM_OBJ + 1);
   localparam int WIDE  = 2 * REG_W;

   if (NUM_OBJ < 1 || NUM_OBJ > WIDE) begin : g_bad_num
      $error("NUM_OBJ must fit in two pending words");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("BUSY_CYC must be at least one");
   end
   if (REG_W < 16 || REG_W <= NUM_W) begin : g_bad_w
      $error("REG_W too narrow");
   end

   logic [2:0]         ctrl_q;
   logic               mask_q;
   logic               stat_q;
   logic               err_q;
   logic               irq_q;
   logic [NUM_OBJ-1:0] pend;
   logic [NUM_OBJ-1:0] clr;
   logic [REG_W-1:0]   cause;
   logic [WIDE-1:0]    pend_wide;
   logic               busy;
   logic [NUM_W-1:0]   cmd_num;
   logic               stat_clr;
   logic               wr_ctrl, wr_mask, wr_req;

   reg_sel_e sel;
   assign sel      = reg_sel_e'(reg_addr);
   assign wr_ctrl  = reg_wr && sel == SEL_CTRL;
   assign wr_mask  = reg_wr && sel == SEL_CMASK;
   assign wr_req   = reg_wr && sel == SEL_CREQ;
   assign stat_clr = reg_rd && sel == SEL_STAT;

   can_irq_pend #(.N(NUM_OBJ)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_i(obj_evt), .clr_i(clr), .pend_o(pend));

   can_irq_cmd #(.N(NUM_OBJ), .BUSY_CYC(BUSY_CYC), .NUM_W(NUM_W)) u_cmd (
      .clk(clk), .rst_n(rst_n), .req_wr(wr_req),
      .req_num(reg_wdata[NUM_W-1:0]), .mask_clr(mask_q),
      .busy_o(busy), .num_o(cmd_num), .clr_o(clr));

   can_irq_prio #(.N(NUM_OBJ), .CW(REG_W), .STATUS_CODE(REG_W'(STATUS_CODE))) u_prio (
      .pend_i(pend), .stat_i(stat_q), .cause_o(cause));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= 1'b0;
         stat_q <= 1'b0;
         err_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= reg_wdata[2:0];
         if (wr_mask) mask_q <= reg_wdata[0];
         stat_q <= stat_evt | (stat_q & ~stat_clr);
         err_q  <= err_evt  | (err_q  & ~stat_clr);
         irq_q  <= ctrl_q[CTRL_MASTER] &
                   ((|pend) | (ctrl_q[CTRL_STAT] & stat_q) | (ctrl_q[CTRL_ERR] & err_q));
      end
   end
   assign irq = irq_q;

   always_comb begin
      pend_wide = '0;
      pend_wide[NUM_OBJ-1:0] = pend;
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_CTRL:  reg_rdata[2:0] = ctrl_q;
         SEL_STAT:  reg_rdata[1:0] = {err_q, stat_q};
         SEL_CAUSE: reg_rdata = cause;
         SEL_PLO:   reg_rdata = pend_wide[REG_W-1:0];
         SEL_PHI:   reg_rdata = pend_wide[WIDE-1:REG_W];
         SEL_CMASK: reg_rdata[0] = mask_q;
         SEL_CREQ: begin
            reg_rdata[REG_W-1]   = busy;
            reg_rdata[NUM_W-1:0] = cmd_num;
         end
         default:   reg_rdata = '0;
      endcase
   end

   assert_cause_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cause == '0) == (pend == '0 && !stat_q));
   assert_stat_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr && !stat_evt) |=> !stat_q);
   assert_master_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_q[CTRL_MASTER] |=> !irq);
endmodule

// File: tb/can_irq_ctrl_tb.sv
module can_irq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] obj_evt = '0;
   logic        stat_evt = 1'b0, err_evt = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;

   always #10 clk = ~clk;

   can_irq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .obj_evt(obj_evt), .stat_evt(stat_evt),
      .err_evt(err_evt), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   int tests = 0, fails = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference state
   logic [32:0] m_pend = '0;
   logic [2:0]  m_ctrl = '0;
   logic        m_mask = 0, m_stat = 0, m_err = 0, m_irq = 0;
   int          m_busy = 0;
   logic [5:0]  m_num = '0;

   function automatic logic [15:0] m_cause();
      if (m_stat) return 16'h8000;
      for (int i = 1; i <= 32; i++) if (m_pend[i]) return 16'(i);
      return 16'h0;
   endfunction

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return {13'b0, m_ctrl};
         3'd1: return {14'b0, m_err, m_stat};
         3'd2: return m_cause();
         3'd3: return m_pend[16:1];
         3'd4: return m_pend[32:17];
         3'd5: return {15'b0, m_mask};
         3'd6: return {(m_busy != 0), 9'b0, m_num};
         default: return 16'h0;
      endcase
   endfunction

   task automatic model_update();
      logic [32:0] clr = '0;
      logic sclr;
      logic any;
      any = 0;
      for (int i = 1; i <= 32; i++) if (m_pend[i]) any = 1;
      m_irq = m_ctrl[0] & (any | (m_ctrl[1] & m_stat) | (m_ctrl[2] & m_err));
      sclr = reg_rd && reg_addr == 3'd1;
      if (reg_wr && reg_addr == 3'd6 && m_busy == 0) begin
         int n;
         n = int'(reg_wdata[5:0]);
         m_num = reg_wdata[5:0];
         m_busy = 3;
         if (m_mask && n >= 1 && n <= 32) clr[n] = 1;
      end else if (m_busy > 0) m_busy--;
      if (reg_wr && reg_addr == 3'd0) m_ctrl = reg_wdata[2:0];
      if (reg_wr && reg_addr == 3'd5) m_mask = reg_wdata[0];
      for (int i = 1; i <= 32; i++) m_pend[i] = obj_evt[i-1] | (m_pend[i] & ~clr[i]);
      m_stat = stat_evt | (m_stat & ~sclr);
      m_err  = err_evt  | (m_err  & ~sclr);
   endtask

   task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("irq", {15'b0, irq}, {15'b0, m_irq});
      chk($sformatf("rdata@%0d", reg_addr), reg_rdata, m_read(reg_addr));
   endtask

   task automatic step(input logic [31:0] ev, input logic st, input logic er,
                       input logic wr, input logic rd, input logic [2:0] a,
                       input logic [15:0] wd);
      obj_evt = ev; stat_evt = st; err_evt = er;
      reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
      @(posedge clk);
      model_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_rd(input logic [2:0] a);
      step('0, 0, 0, 0, 0, a, '0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      step('0, 0, 0, 1, 0, a, d);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state on every address
      cur_req = "R1";
      for (int a = 0; a < 8; a++) idle_rd(3'(a));
      chk("irq after reset", {15'b0, irq}, 16'h0);

      // R9: control write and readback
      cur_req = "R9";
      wr(3'd0, 16'hFFF7);
      idle_rd(3'd0);
      chk("ctrl literal", reg_rdata, 16'h0007);
      idle_rd(3'd7);

      // R2: object events map to the two pending words
      cur_req = "R2";
      step(32'h0008_0010, 0, 0, 0, 0, 3'd3, '0);   // objects 5 and 20
      idle_rd(3'd3);
      chk("low word literal", reg_rdata, 16'h0010);
      idle_rd(3'd4);
      chk("high word literal", reg_rdata, 16'h0008);

      // R3: lowest number wins, status code overrides
      cur_req = "R3";
      idle_rd(3'd2);
      chk("cause literal 5", reg_rdata, 16'd5);
      step(32'h0000_0001, 0, 0, 0, 0, 3'd2, '0);
      idle_rd(3'd2);
      chk("cause literal 1", reg_rdata, 16'd1);
      step('0, 1, 1, 0, 0, 3'd2, '0);
      chk("cause status literal", reg_rdata, 16'h8000);

      // R4: status read clears status and error
      cur_req = "R4";
      step('0, 0, 0, 0, 1, 3'd1, '0);
      idle_rd(3'd1);
      chk("status cleared", reg_rdata, 16'h0);
      step('0, 1, 0, 0, 1, 3'd1, '0);              // event with read keeps flag
      idle_rd(3'd1);
      step('0, 0, 0, 0, 1, 3'd1, '0);

      // R5: clear command
      cur_req = "R5";
      wr(3'd5, 16'h0001);
      wr(3'd6, 16'd1);
      repeat (3) idle_rd(3'd6);
      idle_rd(3'd2);
      chk("cause after clear", reg_rdata, 16'd5);
      wr(3'd6, 16'd0);                             // number 0 clears nothing
      repeat (3) idle_rd(3'd3);
      wr(3'd6, 16'd40);                            // out of range
      repeat (3) idle_rd(3'd4);

      // R6: busy window and ignored write
      cur_req = "R6";
      wr(3'd6, 16'd5);
      wr(3'd6, 16'd20);                            // ignored while busy
      idle_rd(3'd6);
      chk("busy num literal", reg_rdata, 16'h8005);
      idle_rd(3'd6);
      idle_rd(3'd6);
      chk("busy done literal", reg_rdata, 16'h0005);
      idle_rd(3'd4);
      chk("obj20 kept", reg_rdata, 16'h0008);

      // R7: set and clear in same cycle
      cur_req = "R7";
      step(32'h0008_0000, 0, 0, 1, 0, 3'd6, 16'd20);
      repeat (3) idle_rd(3'd4);
      chk("obj20 set wins", reg_rdata, 16'h0008);

      cur_req = "R5";
      wr(3'd5, 16'h0000);
      wr(3'd6, 16'd20);                            // mask clear: no effect
      repeat (3) idle_rd(3'd4);
      chk("mask off literal", reg_rdata, 16'h0008);

      // R8: enable gating of the line
      cur_req = "R8";
      wr(3'd0, 16'h0000);
      idle_rd(3'd0); idle_rd(3'd0);
      chk("irq masked", {15'b0, irq}, 16'h0);
      wr(3'd0, 16'h0001);
      idle_rd(3'd0); idle_rd(3'd0);
      wr(3'd5, 16'h0001);
      wr(3'd6, 16'd20);
      repeat (4) idle_rd(3'd4);
      step('0, 0, 1, 0, 0, 3'd1, '0);
      repeat (2) idle_rd(3'd1);
      wr(3'd0, 16'h0005);
      repeat (2) idle_rd(3'd1);
      step('0, 1, 0, 1, 0, 3'd0, 16'h0003);
      step('0, 0, 0, 0, 1, 3'd1, '0);
      repeat (2) idle_rd(3'd2);

      // random traffic against the model
      cur_req = "random";
      for (int c = 0; c < 4000; c++) begin
         logic [31:0] ev;
         int r;
         ev = '0;
         for (int b = 0; b < 32; b++) if ($urandom_range(0, 15) == 0) ev[b] = 1'b1;
         r = $urandom_range(0, 3);
         step(ev, $urandom_range(0, 19) == 0, $urandom_range(0, 29) == 0,
              r == 0, r == 1, 3'($urandom_range(0, 7)), 16'($urandom));
      end
      done = 1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 200000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule